// File: doc/BRIEF.md
# Externally Triggered Three-Channel PWM Timer

This block is a free-running up-counter that generates three pulse-width-modulated outputs with a common period. The counter stays parked until an edge arrives on an external trigger pin. The active edge is programmable. Once that edge is seen, the counter clears and begins a new period. Every later qualifying edge restarts the period from zero. The period and the three pulse widths are measured in ticks of a count-clock enable.

Software loads four compare values through a simple write port. Address 0 holds the period value P. Addresses 1 to 3 hold the pulse widths of channels 1 to 3. These values are double-buffered. Writes land in shadow registers, and only a write to the channel-1 width arms a transfer. The transfer copies all shadow values into the working set together. It happens at the next period wrap or trigger restart, so an output never mixes an old period with a new width.

A second external input, the event-count pin, has its own edge selector and produces a one-cycle pulse for each qualifying edge. The live counter value is always readable on an output port.

Top module: `trig_pwm3_timer`

## Requirements
- R1: After reset, and until the first qualifying trigger edge, `cnt_value` reads 0 and all bits of `pwm_out` are low.
- R2: Once started with `count_en` held high, the counter steps 0, 1, ..., P and then wraps to 0. A period therefore lasts P+1 count ticks, and `cnt_value` always shows the present count.
- R3: Output channel k (bit k-1 of `pwm_out`) is high while the count is below its width Wk and low otherwise. Wk = 0 keeps the output low for the whole period. Wk > P keeps it high for the whole period.
- R4: Writes to address 0 (period), address 2 and address 3 (widths 2 and 3) do not change any output until address 1 (width 1) is written. After that write, all four shadow values take effect together at the next wrap or trigger restart.
- R5: `trig_sel` encodes the qualifying trigger edge as 00 = none, 01 = rising, 10 = falling, 11 = both. An edge of a kind that is not selected leaves the count undisturbed.
- R6: A qualifying trigger edge restarts a running or idle counter at 0. With `count_en` high, the count reads 0 after the third rising clock edge that follows the input change. This delay comes from two synchronizer flops plus the edge stage.
- R7: `evt_edge` pulses high for exactly one clock per qualifying edge on `evt_in`, with `evt_sel` using the same encoding as R5.
- R8: While `tmr_en` is low, the counter reads 0, all outputs are low and trigger edges are discarded. After `tmr_en` returns high, a fresh trigger edge is needed to start.
- R9: While `count_en` is low, the count holds its value. A trigger edge seen in that time is remembered and restarts the counter on the next enabled tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Timer enable; low forces idle |
| count_en | input | 1 | Count-clock tick enable |
| trig_sel | input | 2 | Trigger edge select |
| evt_sel | input | 2 | Event input edge select |
| trig_in | input | 1 | External trigger pin (asynchronous) |
| evt_in | input | 1 | External event pin (asynchronous) |
| wr_en | input | 1 | Compare register write strobe |
| wr_addr | input | AW (2) | Compare register index, 0 to 3 |
| wr_data | input | CNT_W (16) | Compare register write value |
| cnt_value | output | CNT_W (16) | Present counter value |
| pwm_out | output | NCH (3) | PWM outputs, active high, bit k-1 is channel k |
| evt_edge | output | 1 | One-cycle pulse per qualifying event edge |

## Verification
The checker relies on reset being held for at least one clock edge, so that the working compare set and the counter start from a shared zero state. It also assumes the external pins change no faster than the synchronizer can follow. The stimulus meets both conditions: it moves the trigger and event pins only on falling clock edges and leaves at least three clocks between changes. It changes the edge selectors only while the pins are steady or while the timer is disabled, so a selector change is never mistaken for an edge. The sweep also keeps every period value small, so that several full periods fit in each configuration.

// File: rtl/tpw_pkg.sv
package tpw_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   // Decide whether a transition between two synchronized samples qualifies.
   function automatic logic edge_hit(input logic [1:0] sel,
                                     input logic       now_v,
                                     input logic       old_v);
      logic rise;
      logic fall;
      rise = now_v & ~old_v;
      fall = ~now_v & old_v;
      case (edge_sel_e'(sel))
         EDGE_RISE: edge_hit = rise;
         EDGE_FALL: edge_hit = fall;
         EDGE_BOTH: edge_hit = rise | fall;
         default:   edge_hit = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/tpw_edge_det.sv
module tpw_edge_det #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   input  logic [1:0] sel,
   output logic       edge_o
);
   import tpw_pkg::*;

   localparam int LAST = STAGES;

   // chain[0..STAGES-1] synchronize; chain[STAGES] holds the previous sample
   logic [LAST:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[LAST-1:0], din};
      end
   end

   always_comb begin
      edge_o = edge_hit(sel, chain[LAST-1], chain[LAST]);
   end

endmodule

// File: rtl/tpw_ccr_bank.sv
module tpw_ccr_bank #(
   parameter int W   = 16,
   parameter int NCH = 3,
   parameter int AW  = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_addr,
   input  logic [W-1:0]           wr_data,
   input  logic                   reload,
   output logic [W-1:0]           act_period,
   output logic [NCH-1:0][W-1:0]  act_duty,
   output logic                   armed
);
   localparam int NREG = NCH + 1;
   localparam logic [AW-1:0] ARM_IDX = AW'(1);

   logic [NREG-1:0][W-1:0] shadow;
   logic                   arm_wr;
   logic                   commit;

   assign arm_wr = wr_en && (wr_addr == ARM_IDX);
   assign commit = reload && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NREG; i++) begin
            if (wr_addr == AW'(i)) begin
               shadow[i] <= wr_data;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else begin
         armed <= (armed && !reload) || arm_wr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_period <= '0;
      end else if (commit) begin
         act_period <= shadow[0];
      end
   end

   for (genvar gk = 0; gk < NCH; gk++) begin : g_duty
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_duty[gk] <= '0;
         end else if (commit) begin
            act_duty[gk] <= shadow[gk+1];
         end
      end
   end

endmodule

// File: rtl/tpw_counter.sv
module tpw_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tmr_en,
   input  logic         count_en,
   input  logic         trig_edge,
   input  logic [W-1:0] period,
   output logic [W-1:0] cnt,
   output logic         running,
   output logic         reload
);
   logic pend;
   logic restart;
   logic wrap;

   assign restart = tmr_en && count_en && (trig_edge || pend);
   assign wrap    = tmr_en && count_en && running && !restart && (cnt == period);
   assign reload  = restart || wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
         pend    <= 1'b0;
      end else if (!tmr_en) begin
         cnt     <= '0;
         running <= 1'b0;
         pend    <= 1'b0;
      end else if (restart) begin
         cnt     <= '0;
         running <= 1'b1;
         pend    <= 1'b0;
      end else begin
         pend <= pend || trig_edge;
         if (count_en && running) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/tpw_pwm_cmp.sv
module tpw_pwm_cmp #(
   parameter int W   = 16,
   parameter int NCH = 3
) (
   input  logic                  tmr_en,
   input  logic                  running,
   input  logic [W-1:0]          cnt,
   input  logic [NCH-1:0][W-1:0] duty,
   output logic [NCH-1:0]        pwm
);
   for (genvar gk = 0; gk < NCH; gk++) begin : g_ch
      assign pwm[gk] = tmr_en && running && (cnt < duty[gk]);
   end

endmodule

// File: rtl/trig_pwm3_timer.sv
module trig_pwm3_timer #(
   parameter int CNT_W       = 16,
   parameter int NCH         = 3,
   parameter int AW          = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_en,
   input  logic             count_en,
   input  logic [1:0]       trig_sel,
   input  logic [1:0]       evt_sel,
   input  logic             trig_in,
   input  logic             evt_in,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_value,
   output logic [NCH-1:0]   pwm_out,
   output logic             evt_edge
);
   localparam int MIN_AW = $clog2(NCH + 1);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("CNT_W must lie in 2..32");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end
   if (AW < MIN_AW) begin : g_bad_aw
      $error("AW too narrow for NCH+1 registers");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                      trig_edge;
   logic                      running;
   logic                      reload;
   logic                      armed;
   logic [CNT_W-1:0]          act_period;
   logic [NCH-1:0][CNT_W-1:0] act_duty;

   tpw_edge_det #(.STAGES(SYNC_STAGES)) u_trig_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (trig_in),
      .sel    (trig_sel),
      .edge_o (trig_edge)
   );

   tpw_edge_det #(.STAGES(SYNC_STAGES)) u_evt_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (evt_in),
      .sel    (evt_sel),
      .edge_o (evt_edge)
   );

   tpw_ccr_bank #(.W(CNT_W), .NCH(NCH), .AW(AW)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .reload     (reload),
      .act_period (act_period),
      .act_duty   (act_duty),
      .armed      (armed)
   );

   tpw_counter #(.W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tmr_en    (tmr_en),
      .count_en  (count_en),
      .trig_edge (trig_edge),
      .period    (act_period),
      .cnt       (cnt_value),
      .running   (running),
      .reload    (reload)
   );

   tpw_pwm_cmp #(.W(CNT_W), .NCH(NCH)) u_cmp (
      .tmr_en  (tmr_en),
      .running (running),
      .cnt     (cnt_value),
      .duty    (act_duty),
      .pwm     (pwm_out)
   );

endmodule

// File: rtl/tpw_checker.sv
module tpw_checker #(
   parameter int W   = 16,
   parameter int NCH = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  tmr_en,
   input logic                  count_en,
   input logic                  running,
   input logic                  armed,
   input logic [W-1:0]          cnt_value,
   input logic [W-1:0]          period,
   input logic [NCH-1:0][W-1:0] act_duty,
   input logic [NCH-1:0]        pwm_out
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (pwm_out == '0));

   // R2
   cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_value <= period);

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en && count_en) |=> (cnt_value == '0) || (cnt_value == $past(cnt_value) + 1'b1));

   // R4
   commit_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(act_duty) || !$stable(period)) |-> $past(armed));

   // R8
   disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_en |=> (cnt_value == '0) && (pwm_out == '0));

   // R9
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en && !count_en) |=> $stable(cnt_value) && $stable(period));

endmodule

bind trig_pwm3_timer tpw_checker #(.W(CNT_W), .NCH(NCH)) u_tpw_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tmr_en    (tmr_en),
   .count_en  (count_en),
   .running   (running),
   .armed     (armed),
   .cnt_value (cnt_value),
   .period    (act_period),
   .act_duty  (act_duty),
   .pwm_out   (pwm_out)
);

// File: tb/trig_pwm3_timer_bench.sv
module trig_pwm3_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tmr_en = 1'b0;
   logic        count_en = 1'b1;
   logic [1:0]  trig_sel = 2'b01;
   logic [1:0]  evt_sel = 2'b00;
   logic        trig_in = 1'b0;
   logic        evt_in = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] cnt_value;
   logic [2:0]  pwm_out;
   logic        evt_edge;

   int nchk = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   trig_pwm3_timer u_trig_pwm3_timer (
      .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .count_en(count_en),
      .trig_sel(trig_sel), .evt_sel(evt_sel), .trig_in(trig_in), .evt_in(evt_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cnt_value(cnt_value), .pwm_out(pwm_out), .evt_edge(evt_edge)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic configure(input int p, input int d1, input int d2, input int d3);
      wr(0, p); wr(2, d2); wr(3, d3); wr(1, d1);
   endtask

   // change trigger pin at a negedge; return at the negedge after the restart edge
   task automatic move_trig(input logic v);
      trig_in = v;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   // run ncyc ticks, starting at phase st, comparing count and outputs
   task automatic run_chk(input string tag, input int p, input int d1, input int d2,
                          input int d3, input int st, input int ncyc);
      for (int i = 0; i < ncyc; i++) begin
         int ph;
         ph = (st + i) % (p + 1);
         chk({tag, " cnt"}, int'(cnt_value), ph);
         chk({tag, " pwm"}, int'(pwm_out), (int'(ph < d3) << 2) | (int'(ph < d2) << 1) | int'(ph < d1));
         @(negedge clk);
      end
   endtask

   // disable, park trigger low, select an edge kind, re-enable
   task automatic rearm(input logic [1:0] sel);
      tmr_en = 1'b0; trig_in = 1'b0; trig_sel = sel;
      repeat (4) @(negedge clk);
      tmr_en = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset cnt", int'(cnt_value), 0);
      chk("R1 reset pwm", int'(pwm_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      tmr_en = 1'b1;
      configure(4, 2, 3, 5);
      repeat (12) @(negedge clk);
      chk("R1 pre-trigger cnt", int'(cnt_value), 0);
      chk("R1 pre-trigger pwm", int'(pwm_out), 0);

      // R2 R3: sweep of periods and widths, rising trigger start
      for (int p = 1; p <= 7; p++) begin
         for (int s = 0; s < 4; s++) begin
            int d1, d2, d3;
            if (s == 3) begin
               d1 = 0; d2 = p; d3 = p + 5;
            end else begin
               d1 = (s * 3 + 1 * (p + 1)) % (p + 3);
               d2 = (s * 3 + 2 * (p + 1)) % (p + 3);
               d3 = (s * 3 + 3 * (p + 1)) % (p + 3);
            end
            rearm(2'b01);
            configure(p, d1, d2, d3);
            move_trig(1'b1);
            run_chk("R2 R3 sweep", p, d1, d2, d3, 0, 2 * (p + 1) + 1);
         end
      end

      // R5 R6: falling select ignores rising, restarts on falling mid-period
      rearm(2'b10);
      trig_in = 1'b1;
      repeat (5) @(negedge clk);
      chk("R5 rise ignored while idle", int'(cnt_value), 0);
      configure(9, 2, 4, 6);
      move_trig(1'b0);
      trig_in = 1'b1;
      run_chk("R5 rise ignored while running", 9, 2, 4, 6, 0, 14);
      move_trig(1'b0);
      run_chk("R6 falling restart", 9, 2, 4, 6, 0, 6);

      // R5 R6: both edges
      trig_sel = 2'b11;
      move_trig(1'b1);
      run_chk("R6 both rise restart", 9, 2, 4, 6, 0, 5);
      move_trig(1'b0);
      run_chk("R6 both fall restart", 9, 2, 4, 6, 0, 5);

      // R5: select none
      rearm(2'b00);
      move_trig(1'b1);
      move_trig(1'b0);
      repeat (4) @(negedge clk);
      chk("R5 none cnt", int'(cnt_value), 0);
      chk("R5 none pwm", int'(pwm_out), 0);

      // R4: buffered reload committed by width-1 write
      rearm(2'b01);
      configure(9, 2, 4, 6);
      move_trig(1'b1);
      run_chk("R4 base", 9, 2, 4, 6, 0, 3);
      wr(2, 8);
      wr(0, 5);
      run_chk("R4 pending", 9, 2, 4, 6, 5, 16);
      wr(1, 1);
      run_chk("R4 armed old", 9, 2, 4, 6, 2, 8);
      run_chk("R4 committed", 5, 1, 8, 6, 0, 12);

      // R9: hold with count_en low, pending trigger
      rearm(2'b01);
      configure(9, 2, 4, 6);
      move_trig(1'b1);
      trig_in = 1'b0;
      run_chk("R9 pre-hold", 9, 2, 4, 6, 0, 2);
      count_en = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R9 hold cnt", int'(cnt_value), 2);
      end
      count_en = 1'b1;
      run_chk("R9 resume", 9, 2, 4, 6, 2, 4);
      count_en = 1'b0;
      trig_in = 1'b1;
      repeat (6) @(negedge clk);
      chk("R9 pending held cnt", int'(cnt_value), 6);
      count_en = 1'b1;
      @(negedge clk);
      run_chk("R9 pending restart", 9, 2, 4, 6, 0, 5);

      // R8: disable clears, needs fresh trigger
      tmr_en = 1'b0;
      @(negedge clk);
      chk("R8 off cnt", int'(cnt_value), 0);
      chk("R8 off pwm", int'(pwm_out), 0);
      trig_in = 1'b0;
      repeat (4) @(negedge clk);
      trig_in = 1'b1;
      repeat (5) @(negedge clk);
      tmr_en = 1'b1;
      repeat (10) @(negedge clk);
      chk("R8 re-enable cnt", int'(cnt_value), 0);
      chk("R8 re-enable pwm", int'(pwm_out), 0);

      // R7: event edge pulses per select code
      for (int sel = 0; sel < 4; sel++) begin
         int pulses;
         int expct;
         evt_sel = 2'(sel);
         pulses = 0;
         for (int t = 0; t < 4; t++) begin
            evt_in = ~evt_in;
            for (int c = 0; c < 5; c++) begin
               @(negedge clk);
               if (evt_edge) pulses++;
            end
         end
         expct = (sel == 0) ? 0 : (sel == 3) ? 4 : 2;
         chk("R7 event pulses", pulses, expct);
      end

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule